// File: doc/BRIEF.md
# Serial Frame Format Bridge

This block is glue logic between a stereo serial port and a telephone line-interface device. The port sends 128-bit frames, left-justified and MSB first, and generates its own bit clock (SCLK) and left/right clock (LRCK). The device uses a 256-bit frame cut into two 128-bit time slots. It expects an active-low frame sync at the start of each slot. The first slot after a sync carries telephony samples (primary) and the next carries host control (secondary). Data words are 16 bits and pass through bit for bit.

All logic runs on the master clock, which is twice the port's bit rate. The bridge samples SCLK and LRCK as ordinary inputs and finds their edges there. Each LRCK rising edge starts a new device slot. At that point the bridge drops the frame sync for one bit period and flips a primary/secondary flag. The two sides use opposite SCLK edges, so the bridge retimes the data in each direction by half a bit. Data headed for the device is captured at SCLK rise and held until the device samples it on the falling edge. Data headed for the port is captured at SCLK fall and held across the port's rising-edge sample point.

Top module: `slot_frame_bridge`

## Requirements
- R1: While reset is low, dev_fsync_n is 1 and slot_valid, slot_primary, dev_sdi, port_sdin and slot_bit are all 0.
- R2: In the master-clock cycle where an LRCK rise is first seen (port_lrck 1 after a sampled 0), dev_fsync_n goes to 0. It stays 0 for FSYNC_BITS*BIT_CLKS cycles (2 by default, one SCLK period) and then returns to 1.
- R3: An LRCK falling edge, or any cycle with no LRCK rise, never pulls dev_fsync_n low.
- R4: slot_primary inverts on each LRCK rise once slot_valid is 1. Between rises it holds its value (1 means primary, 0 means secondary).
- R5: The first LRCK rise after reset sets slot_valid to 1 and marks the slot as primary. If LRCK is already high when reset is released, that level is not treated as a rise.
- R6: At each detected SCLK rise, dev_sdi takes the value on port_sdout. It holds that value at all other times, so 16-bit words arrive at the device MSB first and in order.
- R7: At each detected SCLK fall, port_sdin takes the value on dev_sdo. It holds that value at all other times.
- R8: slot_bit is set to 0 on an LRCK rise. On every other SCLK fall it advances by one, wrapping from SLOT_BITS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sclk | input | 1 | Bit clock from the serial port |
| port_lrck | input | 1 | Left/right clock from the serial port |
| port_sdout | input | 1 | Serial data from the port |
| port_sdin | output | 1 | Retimed device data toward the port |
| dev_fsync_n | output | 1 | Active-low frame sync to the device |
| dev_sdi | output | 1 | Retimed port data toward the device |
| dev_sdo | input | 1 | Serial data from the device |
| slot_valid | output | 1 | A slot boundary has been seen since reset |
| slot_primary | output | 1 | 1 in the primary slot, 0 in the secondary |
| slot_bit | output | $clog2(SLOT_BITS) | Index of the current bit within the slot |

## Verification
The bench first drives half a slot with LRCK low, then releases a reset in the middle of a slot while LRCK is high. A design that treated an existing high level as an edge would report a primary slot one slot early. It also flips LRCK in the same step as SCLK falls. A design that let the bit counter's increment win over its clear would start each slot at index 1 instead of 0. Scoreboards compare every bit in both directions. A retimer sampling on the wrong edge would hand each side the bit from the previous half-period, and the comparison would catch it. The sync width is checked both one and two cycles after each boundary, and a stretched or missing pulse fails those checks.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

   typedef enum logic {
      SLOT_SECONDARY = 1'b0,
      SLOT_PRIMARY   = 1'b1
   } slot_kind_e;

   function automatic int unsigned width_of(input int unsigned count);
      return (count < 2) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/sfb_edge_detect.sv
module sfb_edge_detect #(
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise,
   output logic fall
);

   logic d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q <= RESET_VAL;
      else        d_q <= d;
   end

   assign rise = d & ~d_q;
   assign fall = ~d & d_q;

endmodule

// File: rtl/sfb_retimer.sv
module sfb_retimer #(
   parameter bit CAPTURE_ON_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_rise,
   input  logic sclk_fall,
   input  logic d,
   output logic q
);

   logic take;

   generate
      if (CAPTURE_ON_RISE) begin : g_rise
         assign take = sclk_rise;
      end else begin : g_fall
         assign take = sclk_fall;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (take) q <= d;
   end

   a_r6_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(q));

   a_r6_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (q == $past(d)));

endmodule

// File: rtl/sfb_fsync_gen.sv
module sfb_fsync_gen #(
   parameter int unsigned LOW_CYCLES = 2,
   localparam int unsigned CNT_W = sfb_pkg::width_of(LOW_CYCLES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic fsync_n
);

   logic [CNT_W-1:0] remain;

   generate
      if (LOW_CYCLES < 1) begin : g_bad_low
         $error("sfb_fsync_gen: LOW_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsync_n <= 1'b1;
         remain  <= '0;
      end else if (start) begin
         fsync_n <= 1'b0;
         remain  <= CNT_W'(LOW_CYCLES - 1);
      end else if (!fsync_n) begin
         if (remain == '0) fsync_n <= 1'b1;
         else              remain  <= remain - 1'b1;
      end
   end

   a_r2_low_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !fsync_n);

endmodule

// File: rtl/sfb_slot_tracker.sv
module sfb_slot_tracker #(
   parameter int unsigned SLOT_BITS = 128,
   localparam int unsigned POS_W = sfb_pkg::width_of(SLOT_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_start,
   input  logic             bit_tick,
   output logic             valid,
   output logic             primary,
   output logic [POS_W-1:0] bit_pos
);
   import sfb_pkg::*;

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_BITS - 1);

   slot_kind_e kind;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         kind  <= SLOT_SECONDARY;
      end else if (slot_start) begin
         valid <= 1'b1;
         kind  <= (!valid || kind == SLOT_SECONDARY) ? SLOT_PRIMARY : SLOT_SECONDARY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             bit_pos <= '0;
      else if (slot_start)    bit_pos <= '0;
      else if (bit_tick)      bit_pos <= (bit_pos == LAST_POS) ? '0 : bit_pos + 1'b1;
   end

   assign primary = (kind == SLOT_PRIMARY);

   a_r8_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start |=> (bit_pos == '0));

   a_r8_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_start && !bit_tick) |=> $stable(bit_pos));

endmodule

// File: rtl/slot_frame_bridge.sv
module slot_frame_bridge #(
   parameter int unsigned SLOT_BITS  = 128,
   parameter int unsigned BIT_CLKS   = 2,
   parameter int unsigned FSYNC_BITS = 1,
   localparam int unsigned POS_W = sfb_pkg::width_of(SLOT_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_sclk,
   input  logic             port_lrck,
   input  logic             port_sdout,
   output logic             port_sdin,
   output logic             dev_fsync_n,
   output logic             dev_sdi,
   input  logic             dev_sdo,
   output logic             slot_valid,
   output logic             slot_primary,
   output logic [POS_W-1:0] slot_bit
);

   localparam int unsigned SYNC_CYCLES = FSYNC_BITS * BIT_CLKS;

   generate
      if (BIT_CLKS < 2 || (BIT_CLKS % 2) != 0) begin : g_bad_clks
         $error("slot_frame_bridge: BIT_CLKS must be even and at least 2");
      end
      if (SLOT_BITS < 16) begin : g_bad_slot
         $error("slot_frame_bridge: SLOT_BITS must hold one 16-bit word");
      end
      if (FSYNC_BITS < 1 || FSYNC_BITS >= SLOT_BITS) begin : g_bad_sync
         $error("slot_frame_bridge: FSYNC_BITS must be within one slot");
      end
   endgenerate

   logic sclk_rise, sclk_fall;
   logic lrck_rise, lrck_fall;

   sfb_edge_detect #(.RESET_VAL(1'b1)) u_sclk_edge (
      .clk(clk), .rst_n(rst_n), .d(port_sclk), .rise(sclk_rise), .fall(sclk_fall));

   sfb_edge_detect #(.RESET_VAL(1'b1)) u_lrck_edge (
      .clk(clk), .rst_n(rst_n), .d(port_lrck), .rise(lrck_rise), .fall(lrck_fall));

   sfb_retimer #(.CAPTURE_ON_RISE(1'b1)) u_to_dev (
      .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .d(port_sdout), .q(dev_sdi));

   sfb_retimer #(.CAPTURE_ON_RISE(1'b0)) u_to_port (
      .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .d(dev_sdo), .q(port_sdin));

   sfb_fsync_gen #(.LOW_CYCLES(SYNC_CYCLES)) u_fsync (
      .clk(clk), .rst_n(rst_n), .start(lrck_rise), .fsync_n(dev_fsync_n));

   sfb_slot_tracker #(.SLOT_BITS(SLOT_BITS)) u_slot (
      .clk(clk), .rst_n(rst_n), .slot_start(lrck_rise), .bit_tick(sclk_fall),
      .valid(slot_valid), .primary(slot_primary), .bit_pos(slot_bit));

   a_r2_sync_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      lrck_rise |=> !dev_fsync_n);

   a_r3_no_sync_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (lrck_fall && dev_fsync_n) |=> dev_fsync_n);

   a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_fsync_n && !lrck_rise) |=> dev_fsync_n);

   a_r4_slot_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (lrck_rise && slot_valid) |=> (slot_primary != $past(slot_primary)));

   a_r4_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !lrck_rise |=> $stable(slot_primary));

   a_r5_first_primary: assert property (@(posedge clk) disable iff (!rst_n)
      (lrck_rise && !slot_valid) |=> (slot_primary && slot_valid));

   a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> (dev_sdi == $past(port_sdout)));

   a_r7_backward: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_fall |=> (port_sdin == $past(dev_sdo)));

endmodule

// File: tb/tb_slot_frame_bridge.sv
`timescale 1ns/1ps
module tb_slot_frame_bridge;

   localparam int SLOT_BITS = 128;
   localparam int POS_W = $clog2(SLOT_BITS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic port_sclk, port_lrck, port_sdout, dev_sdo;
   logic port_sdin, dev_fsync_n, dev_sdi, slot_valid, slot_primary;
   logic [POS_W-1:0] slot_bit;

   always #2.5 clk = ~clk;

   slot_frame_bridge dut (
      .clk(clk), .rst_n(rst_n), .port_sclk(port_sclk), .port_lrck(port_lrck),
      .port_sdout(port_sdout), .port_sdin(port_sdin), .dev_fsync_n(dev_fsync_n),
      .dev_sdi(dev_sdi), .dev_sdo(dev_sdo), .slot_valid(slot_valid),
      .slot_primary(slot_primary), .slot_bit(slot_bit));

   typedef struct { logic d; int pos; } fwd_t;
   fwd_t q_fwd[$];
   logic q_rev[$];
   logic q_slot[$];

   int errors = 0;
   int checks = 0;
   bit finished = 0;
   int exp_pos = 0;
   bit exp_valid = 0;
   logic exp_prim = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // driver: one bit per call, falling half then rising half
   task automatic send_bit(input logic lr, input logic dout, input logic ddev);
      fwd_t it;
      logic lr_rise;
      @(negedge clk);
      lr_rise = lr & ~port_lrck;
      port_sclk = 1'b0;
      port_lrck = lr;
      port_sdout = dout;
      if (lr_rise) exp_pos = 0;
      else exp_pos = (exp_pos == SLOT_BITS - 1) ? 0 : exp_pos + 1;
      if (lr_rise) begin
         exp_prim = exp_valid ? ~exp_prim : 1'b1;
         exp_valid = 1;
         q_slot.push_back(exp_prim);
      end
      it.d = dout;
      it.pos = exp_pos;
      q_fwd.push_back(it);
      @(negedge clk);
      port_sclk = 1'b1;
      dev_sdo = ddev;
      q_rev.push_back(ddev);
   endtask

   task automatic run_slot(input int s, input int first, input int last);
      for (int b = first; b <= last; b++) begin
         logic [15:0] wo, wd;
         wo = 16'hA5C3 ^ 16'((s * 8 + b / 16) * 16'h1357);
         wd = 16'h3C96 ^ 16'((s * 8 + b / 16) * 16'h0F21);
         send_bit(b < SLOT_BITS / 2, wo[15 - (b % 16)], wd[15 - (b % 16)]);
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      q_fwd.delete();
      q_rev.delete();
      q_slot.delete();
      exp_pos = 0;
      exp_valid = 0;
      exp_prim = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 fsync_n", 32'(dev_fsync_n), 32'd1);
      check("R1 slot_valid", 32'(slot_valid), 32'd0);
      check("R1 slot_primary", 32'(slot_primary), 32'd0);
      check("R1 dev_sdi", 32'(dev_sdi), 32'd0);
      check("R1 port_sdin", 32'(port_sdin), 32'd0);
      check("R1 slot_bit", 32'(slot_bit), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // monitor: port to device data and bit index (R6, R8)
   initial forever begin
      @(posedge port_sclk);
      @(posedge clk);
      #1;
      if (q_fwd.size() > 0) begin
         fwd_t it;
         it = q_fwd.pop_front();
         check("R6 dev_sdi", 32'(dev_sdi), 32'(it.d));
         check("R8 slot_bit", 32'(slot_bit), 32'(it.pos));
      end
   end

   // monitor: device to port data (R7)
   initial forever begin
      @(negedge port_sclk);
      @(posedge clk);
      #1;
      if (q_rev.size() > 0) begin
         logic e;
         e = q_rev.pop_front();
         check("R7 port_sdin", 32'(port_sdin), 32'(e));
      end
   end

   // monitor: slot boundary, sync pulse, slot flag (R2, R4, R5)
   initial forever begin
      @(posedge port_lrck);
      @(posedge clk);
      #1;
      if (q_slot.size() > 0) begin
         logic e;
         e = q_slot.pop_front();
         check("R2 sync low at boundary", 32'(dev_fsync_n), 32'd0);
         check("R4 R5 slot_primary", 32'(slot_primary), 32'(e));
         check("R5 slot_valid", 32'(slot_valid), 32'd1);
         @(posedge clk);
         #1;
         check("R2 sync low second cycle", 32'(dev_fsync_n), 32'd0);
         @(posedge clk);
         #1;
         check("R2 sync released", 32'(dev_fsync_n), 32'd1);
      end
   end

   // monitor: LRCK fall gives no sync and keeps the slot flag (R3, R4)
   initial forever begin
      logic held;
      @(negedge port_lrck);
      held = slot_primary;
      @(posedge clk);
      #1;
      check("R3 no sync on LRCK fall", 32'(dev_fsync_n), 32'd1);
      check("R4 flag held on LRCK fall", 32'(slot_primary), 32'(held));
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      port_sclk = 1'b1;
      port_lrck = 1'b0;
      port_sdout = 1'b0;
      dev_sdo = 1'b0;
      apply_reset();
      // partial slot with LRCK low: nothing is a boundary yet
      run_slot(0, SLOT_BITS / 2, SLOT_BITS - 1);
      @(negedge clk);
      check("R5 no slot before first rise", 32'(slot_valid), 32'd0);
      check("R3 sync idle before first rise", 32'(dev_fsync_n), 32'd1);
      for (int s = 1; s <= 4; s++) run_slot(s, 0, SLOT_BITS - 1);
      // reset in the middle of a slot with LRCK high
      run_slot(5, 0, 29);
      apply_reset();
      run_slot(5, 30, SLOT_BITS - 1);
      @(negedge clk);
      check("R5 high LRCK at release is not a rise", 32'(slot_valid), 32'd0);
      for (int s = 6; s <= 8; s++) run_slot(s, 0, SLOT_BITS - 1);
      repeat (4) @(negedge clk);
      check("R8 scoreboard drained", 32'(q_fwd.size()), 32'd0);
      finished = 1;
      summary();
      $finish;
   end

endmodule